// File: doc/BRIEF.md
# DMA interrupt register sequencer

This block takes the byte writes aimed at one control register of a DMA controller. The first byte of a group is a base byte. Flag bits in the base byte decide whether a two-byte port B start address and an interrupt control byte follow it. Flag bits in the interrupt control byte then decide whether a pulse control byte and an interrupt vector byte follow. Each byte is stored in its own field register. The fields stay valid until they are overwritten.

The stored interrupt control field selects which of three conditions may interrupt: a pattern match, end of block, and the ready line becoming active. Match and end-of-block events are held pending until the bus has been released. They raise the request only while the interrupt logic is armed. The logic is armed either by an enable command pulse or by a level from another control register. A ready edge raises the request at once, without waiting for any bus state. The request stays high until it is cleared.

Top module: `dma_irq_seqr`

## Requirements
- R1: After reset, `busy_o` and `irq_o` are 0, `irq_cause_o` is 0, and every field output is 0.
- R2: A write taken in idle is a base byte and is shown on `base_o`. The trailing bytes it asks for arrive in this fixed order: address low byte if base bit 2 is 1, address high byte if base bit 3 is 1, interrupt control byte if base bit 4 is 1. Any byte whose flag bit is 0 is skipped. The address bytes form `portb_addr_o[7:0]` and `portb_addr_o[15:8]`.
- R3: After an interrupt control byte, a pulse control byte follows if bit 3 of that byte is 1. A vector byte follows if bit 4 of that byte is 1. When both bits are set, the pulse control byte comes first.
- R4: `busy_o` is 1 while a trailing byte is still expected. It drops to 0 in the cycle after the last required byte, or after a base byte that asks for none. The next write is then a new base byte. Fields that a sequence does not write keep their values.
- R5: A pulse on `cmd_reset_i` returns the sequencer to idle and drops any partial sequence. A write in the same cycle is ignored. Fields already written are kept.
- R6: A match event interrupts only if interrupt control bit 0 is 1 and either `stop_match_i` or `stop_eob_i` is 1 when the event occurs. The event is then held pending. The request rises one cycle after `bus_released_i` and the arm condition are both true. The match cause is `irq_cause_o[0]`.
- R7: An end-of-block event interrupts only if interrupt control bit 1 is 1 and `stop_eob_i` is 1. It is then held pending and released under the same bus and arm rule as R6. The end-of-block cause is `irq_cause_o[1]`.
- R8: When interrupt control bit 6 is 1 and the logic is armed, a rising edge of `rdy_i` raises `irq_o` one cycle later, whatever the state of `bus_released_i`. A level that stays high raises nothing further. The ready cause is `irq_cause_o[2]`.
- R9: No request is raised unless the logic is armed. It is armed by a `cmd_ei_i` pulse, which stays in effect until reset, or while `cfg_ie_i` is 1. A pending match or end-of-block event fires once the logic becomes armed.
- R10: `irq_o` and `irq_cause_o` hold until `irq_clr_i` is applied. The clear also drops pending events, and it wins over a request set in the same cycle.
- R11: When a condition's bit in the interrupt control field is 0, its events never interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Byte write strobe for this register |
| wr_data_i | input | 8 | Written byte |
| cmd_reset_i | input | 1 | Command pulse: return the sequencer to idle |
| cmd_ei_i | input | 1 | Command pulse: arm the interrupt logic |
| cfg_ie_i | input | 1 | Interrupt enable level from another control register |
| stop_match_i | input | 1 | Stop-on-match mode is programmed |
| stop_eob_i | input | 1 | Stop-on-end-of-block mode is programmed |
| match_evt_i | input | 1 | Match event pulse |
| eob_evt_i | input | 1 | End-of-block event pulse |
| bus_released_i | input | 1 | The DMA has released the bus |
| rdy_i | input | 1 | Ready line |
| irq_clr_i | input | 1 | Clears the request, its causes and pending events |
| busy_o | output | 1 | A trailing byte is expected |
| base_o | output | 8 | Last base byte |
| portb_addr_o | output | 16 | Port B start address |
| int_ctrl_o | output | 8 | Interrupt control field |
| pulse_ctrl_o | output | 8 | Pulse control field |
| vector_o | output | 8 | Interrupt vector field |
| irq_o | output | 1 | Interrupt request |
| irq_cause_o | output | 3 | Causes: [0] match, [1] end of block, [2] ready |

## Verification
If the sequencer lands in the wrong state, the next byte is stored in the wrong field. That mismatch shows on the field outputs one cycle after the write, and `busy_o` stays high or drops too early in that same cycle. A wrong pending or arm flag shows as `irq_o` rising one cycle early or late, or not rising at all. A cause bit that is wrong stays visible until the clear. The bench therefore samples fields and `busy_o` after every byte, and it samples `irq_o` both in the cycle where it must stay low and in the cycle where it must rise.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;
  localparam int NCAUSE = 3;

  // flag positions that select trailing bytes
  localparam int B_ADR_LO = 2;
  localparam int B_ADR_HI = 3;
  localparam int B_ICTL   = 4;
  localparam int I_PCTL   = 3;
  localparam int I_VEC    = 4;
  // condition enables in the interrupt control field
  localparam int I_MATCH  = 0;
  localparam int I_EOB    = 1;
  localparam int I_RDY    = 6;
  // cause bit order
  localparam int C_MATCH  = 0;
  localparam int C_EOB    = 1;
  localparam int C_RDY    = 2;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_ADR_LO = 3'd1,
    S_ADR_HI = 3'd2,
    S_ICTL   = 3'd3,
    S_PCTL   = 3'd4,
    S_VEC    = 3'd5
  } seq_state_e;

  function automatic seq_state_e after_base(input logic [BYTE_W-1:0] b);
    if (b[B_ADR_LO])      return S_ADR_LO;
    else if (b[B_ADR_HI]) return S_ADR_HI;
    else if (b[B_ICTL])   return S_ICTL;
    else                  return S_IDLE;
  endfunction

  function automatic seq_state_e after_ictl(input logic [BYTE_W-1:0] c);
    if (c[I_PCTL])     return S_PCTL;
    else if (c[I_VEC]) return S_VEC;
    else               return S_IDLE;
  endfunction
endpackage

// File: rtl/dma_irq_fsm.sv
module dma_irq_fsm
  import dma_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              cmd_reset_i,
  output seq_state_e        state_o,
  output logic              take_o,
  output logic              busy_o
);
  seq_state_e state_q, state_d;
  logic hi_q, ictl_q, vec_q;   // pending flags captured from earlier bytes
  logic hi_d, ictl_d, vec_d;

  assign take_o = wr_valid_i && !cmd_reset_i;

  always_comb begin
    state_d = state_q;
    hi_d    = hi_q;
    ictl_d  = ictl_q;
    vec_d   = vec_q;
    if (cmd_reset_i) begin
      state_d = S_IDLE;
    end else if (wr_valid_i) begin
      unique case (state_q)
        S_IDLE: begin
          state_d = after_base(wr_data_i);
          hi_d    = wr_data_i[B_ADR_HI];
          ictl_d  = wr_data_i[B_ICTL];
        end
        S_ADR_LO: begin
          if (hi_q)        state_d = S_ADR_HI;
          else if (ictl_q) state_d = S_ICTL;
          else             state_d = S_IDLE;
        end
        S_ADR_HI: state_d = ictl_q ? S_ICTL : S_IDLE;
        S_ICTL: begin
          state_d = after_ictl(wr_data_i);
          vec_d   = wr_data_i[I_VEC];
        end
        S_PCTL:  state_d = vec_q ? S_VEC : S_IDLE;
        S_VEC:   state_d = S_IDLE;
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      hi_q    <= 1'b0;
      ictl_q  <= 1'b0;
      vec_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      hi_q    <= hi_d;
      ictl_q  <= ictl_d;
      vec_q   <= vec_d;
    end
  end

  assign state_o = state_q;
  assign busy_o  = (state_q != S_IDLE);

  a_r5_cmd_reset_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_reset_i |=> !busy_o);
  a_r4_vec_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_VEC && wr_valid_i) |=> !busy_o);
  a_r2_legal_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q inside {S_IDLE, S_ADR_LO, S_ADR_HI, S_ICTL, S_PCTL, S_VEC});
endmodule

// File: rtl/dma_irq_fields.sv
module dma_irq_fields
  import dma_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  seq_state_e        state_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] base_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] ictl_o,
  output logic [BYTE_W-1:0] pctl_o,
  output logic [BYTE_W-1:0] vec_o
);
  localparam int NF = 6;
  logic [NF-1:0]     we;
  logic [BYTE_W-1:0] fld_q [NF];

  // field index equals the state that accepts it
  for (genvar i = 0; i < NF; i++) begin : g_fld
    assign we[i] = take_i && (state_i == seq_state_e'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    fld_q[i] <= '0;
      else if (we[i]) fld_q[i] <= wr_data_i;
    end
  end

  assign base_o = fld_q[S_IDLE];
  assign addr_o = {fld_q[S_ADR_HI], fld_q[S_ADR_LO]};
  assign ictl_o = fld_q[S_ICTL];
  assign pctl_o = fld_q[S_PCTL];
  assign vec_o  = fld_q[S_VEC];

  a_r4_one_field_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we));
endmodule

// File: rtl/dma_irq_gate.sv
module dma_irq_gate
  import dma_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] ictl_i,
  input  logic              cmd_ei_i,
  input  logic              cfg_ie_i,
  input  logic              stop_match_i,
  input  logic              stop_eob_i,
  input  logic              match_evt_i,
  input  logic              eob_evt_i,
  input  logic              bus_released_i,
  input  logic              rdy_i,
  input  logic              irq_clr_i,
  output logic              irq_o,
  output logic [NCAUSE-1:0] cause_o
);
  logic armed_q, rdy_q, pm_q, pe_q, irq_q;
  logic [NCAUSE-1:0] cause_q, fire;
  logic en, rdy_rise;

  assign en       = armed_q || cfg_ie_i;
  assign rdy_rise = rdy_i && !rdy_q;

  assign fire[C_MATCH] = pm_q && bus_released_i && en;
  assign fire[C_EOB]   = pe_q && bus_released_i && en;
  assign fire[C_RDY]   = rdy_rise && ictl_i[I_RDY] && en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      rdy_q   <= 1'b0;
      pm_q    <= 1'b0;
      pe_q    <= 1'b0;
      irq_q   <= 1'b0;
      cause_q <= '0;
    end else begin
      rdy_q <= rdy_i;
      if (cmd_ei_i) armed_q <= 1'b1;
      if (irq_clr_i) begin
        pm_q    <= 1'b0;
        pe_q    <= 1'b0;
        irq_q   <= 1'b0;
        cause_q <= '0;
      end else begin
        if (match_evt_i && ictl_i[I_MATCH] && (stop_match_i || stop_eob_i)) pm_q <= 1'b1;
        if (eob_evt_i && ictl_i[I_EOB] && stop_eob_i)                       pe_q <= 1'b1;
        if (|fire) irq_q <= 1'b1;
        cause_q <= cause_q | fire;
      end
    end
  end

  assign irq_o   = irq_q;
  assign cause_o = cause_q;

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);
  a_r10_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_clr_i |=> (!irq_o && cause_o == '0));
  a_r6_bus_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_o) && cause_o[C_MATCH]) |-> $past(bus_released_i));
  a_r9_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(armed_q || cfg_ie_i));
  a_r11_cond_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|(ictl_i & 8'h43) || pm_q || pe_q));
endmodule

// File: rtl/dma_irq_seqr.sv
module dma_irq_seqr
  import dma_irq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_valid_i,
  input  logic [7:0]  wr_data_i,
  input  logic        cmd_reset_i,
  input  logic        cmd_ei_i,
  input  logic        cfg_ie_i,
  input  logic        stop_match_i,
  input  logic        stop_eob_i,
  input  logic        match_evt_i,
  input  logic        eob_evt_i,
  input  logic        bus_released_i,
  input  logic        rdy_i,
  input  logic        irq_clr_i,
  output logic        busy_o,
  output logic [7:0]  base_o,
  output logic [15:0] portb_addr_o,
  output logic [7:0]  int_ctrl_o,
  output logic [7:0]  pulse_ctrl_o,
  output logic [7:0]  vector_o,
  output logic        irq_o,
  output logic [2:0]  irq_cause_o
);
  seq_state_e        state;
  logic              take;
  logic [BYTE_W-1:0] ictl;

  dma_irq_fsm u_fsm (
    .clk_i, .rst_ni, .wr_valid_i, .wr_data_i, .cmd_reset_i,
    .state_o(state), .take_o(take), .busy_o(busy_o)
  );

  dma_irq_fields u_fields (
    .clk_i, .rst_ni, .take_i(take), .state_i(state), .wr_data_i,
    .base_o(base_o), .addr_o(portb_addr_o), .ictl_o(ictl),
    .pctl_o(pulse_ctrl_o), .vec_o(vector_o)
  );

  dma_irq_gate u_gate (
    .clk_i, .rst_ni, .ictl_i(ictl), .cmd_ei_i, .cfg_ie_i,
    .stop_match_i, .stop_eob_i, .match_evt_i, .eob_evt_i,
    .bus_released_i, .rdy_i, .irq_clr_i,
    .irq_o(irq_o), .cause_o(irq_cause_o)
  );

  assign int_ctrl_o = ictl;
endmodule

// File: tb/dma_irq_seqr_test.sv
module dma_irq_seqr_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_v = 0, cmd_rst = 0, cmd_ei = 0, cfg_ie = 0, s_match = 0, s_eob = 0;
  logic m_evt = 0, e_evt = 0, rel = 0, rdy = 0, clr = 0;
  logic [7:0] wd = 0;
  logic busy, irq;
  logic [7:0] base, ictl, pctl, vec;
  logic [15:0] addr;
  logic [2:0] cause;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  dma_irq_seqr uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_v), .wr_data_i(wd),
    .cmd_reset_i(cmd_rst), .cmd_ei_i(cmd_ei), .cfg_ie_i(cfg_ie),
    .stop_match_i(s_match), .stop_eob_i(s_eob), .match_evt_i(m_evt),
    .eob_evt_i(e_evt), .bus_released_i(rel), .rdy_i(rdy), .irq_clr_i(clr),
    .busy_o(busy), .base_o(base), .portb_addr_o(addr), .int_ctrl_o(ictl),
    .pulse_ctrl_o(pctl), .vector_o(vec), .irq_o(irq), .irq_cause_o(cause)
  );

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    wr_v = 1; wd = d; tick(); wr_v = 0;
  endtask

  task automatic pulse_clr(); clr = 1; tick(); clr = 0; tick(); endtask

  // {n, b0..b5, exp addr, ictl, pctl, vec}
  typedef struct packed {
    logic [3:0] n; logic [47:0] b;
    logic [15:0] a; logic [7:0] ic, pc, vc;
  } row_t;
  localparam int NR = 7;
  localparam row_t VEC [NR] = '{
    '{4'd1, 48'h00_00_00_00_00_00, 16'h0000, 8'h00, 8'h00, 8'h00},
    '{4'd6, 48'h1C_34_12_18_A5_5C, 16'h1234, 8'h18, 8'hA5, 8'h5C},
    '{4'd2, 48'h04_77_00_00_00_00, 16'h1277, 8'h18, 8'hA5, 8'h5C},
    '{4'd2, 48'h08_AB_00_00_00_00, 16'hAB77, 8'h18, 8'hA5, 8'h5C},
    '{4'd3, 48'h10_10_99_00_00_00, 16'hAB77, 8'h10, 8'hA5, 8'h99},
    '{4'd3, 48'h10_08_3C_00_00_00, 16'hAB77, 8'h08, 8'h3C, 8'h99},
    '{4'd3, 48'h14_01_00_00_00_00, 16'hAB01, 8'h00, 8'h3C, 8'h99}
  };

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tick(); tick();
    // R1 reset state
    chk("R1 busy", busy, 0); chk("R1 irq", irq, 0); chk("R1 cause", cause, 0);
    chk("R1 fields", {base, addr, ictl, pctl, vec}, 0);
    rst_n = 1; tick();

    // R2 R3 R4 table walk
    for (int r = 0; r < NR; r++) begin
      for (int k = 0; k < VEC[r].n; k++) begin
        wr(VEC[r].b[47-8*k -: 8]);
        chk("R4 busy", busy, (k < VEC[r].n - 1));
      end
      chk("R2 base", base, VEC[r].b[47:40]);
      chk("R2 addr", addr, VEC[r].a);
      chk("R3 ictl", ictl, VEC[r].ic);
      chk("R3 pctl", pctl, VEC[r].pc);
      chk("R3 vec", vec, VEC[r].vc);
    end

    // R5 reset drops partial sequence, write in same cycle ignored
    wr(8'h1C); wr(8'h55);
    chk("R5 busy mid", busy, 1);
    cmd_rst = 1; wr_v = 1; wd = 8'hEE; tick(); cmd_rst = 0; wr_v = 0;
    chk("R5 idle", busy, 0);
    chk("R5 kept", addr, 16'hAB55);
    wr(8'h04); wr(8'h66);
    chk("R5 new base", {base, addr}, {8'h04, 16'hAB66});

    // program ictl = 0x43
    wr(8'h10); wr(8'h43);
    chk("R3 ictl43", {busy, ictl}, {1'b0, 8'h43});
    s_eob = 1;

    // R9 arm via cfg level, R8 ready edge
    cfg_ie = 1; rdy = 1; tick();
    chk("R8 rdy irq", {irq, cause}, {1'b1, 3'b100});
    rdy = 0; cfg_ie = 0; pulse_clr();
    chk("R10 cleared", {irq, cause}, 0);

    // R9 not armed: match held pending
    rel = 1; m_evt = 1; tick(); m_evt = 0; tick(); tick();
    chk("R9 unarmed", irq, 0);
    cmd_ei = 1; tick(); cmd_ei = 0;
    chk("R9 arm lag", irq, 0);
    tick();
    chk("R9 R6 fire", {irq, cause}, {1'b1, 3'b001});
    for (int i = 0; i < 5; i++) tick();
    chk("R10 hold", irq, 1);
    pulse_clr();
    chk("R10 clr", {irq, cause}, 0);

    // R6 bus not released
    rel = 0; m_evt = 1; tick(); m_evt = 0; tick(); tick();
    chk("R6 no release", irq, 0);
    rel = 1; tick();
    chk("R6 released", {irq, cause}, {1'b1, 3'b001});
    pulse_clr();

    // R7 end of block needs stop_eob
    s_eob = 0; e_evt = 1; tick(); e_evt = 0; tick(); tick();
    chk("R7 no stop", irq, 0);
    s_eob = 1; e_evt = 1; tick(); e_evt = 0; tick();
    chk("R7 fire", {irq, cause}, {1'b1, 3'b010});
    pulse_clr();

    // R6 stop_match alone; no stop mode
    s_eob = 0; s_match = 1; m_evt = 1; tick(); m_evt = 0; tick();
    chk("R6 stop match", {irq, cause}, {1'b1, 3'b001});
    pulse_clr();
    s_match = 0; m_evt = 1; tick(); m_evt = 0; tick(); tick();
    chk("R6 no stop", irq, 0);

    // R8 edge only, bus not needed
    rel = 0; rdy = 1; tick();
    chk("R8 edge", {irq, cause}, {1'b1, 3'b100});
    pulse_clr(); tick();
    chk("R8 level", irq, 0);
    rdy = 0; tick();

    // R10 clear wins over same-cycle set
    rdy = 1; clr = 1; tick(); clr = 0; tick();
    chk("R10 clr wins", irq, 0);
    rdy = 0; tick();

    // R11 all conditions off
    wr(8'h10); wr(8'h00);
    s_eob = 1; s_match = 1; rel = 1;
    m_evt = 1; e_evt = 1; rdy = 1; tick();
    m_evt = 0; e_evt = 0; tick(); tick();
    chk("R11 disabled", {irq, cause}, 0);
    rdy = 0; tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule